// File: doc/BRIEF.md
# Six-Pin General-Purpose I/O Port with Pad Overrides

This block is one six-pin general-purpose I/O port that software reaches through three small registers. Five of the pins are bidirectional. Each of them has a direction bit and an output-latch bit, and each feeds a pad cell with an output enable and an output value. The sixth pin can only be an input. A static configuration bit chooses its role. It is either a plain digital input that software can read, or an active-low master-reset pin that raises a reset request.

Two other agents can take a bidirectional pin away from software, in a fixed priority order:

- An LCD segment driver wins over everything else. While it holds a pin, that pin drives the segment value and its port read bit is masked to 0.
- A peripheral override comes next. It can force the pin to input, or to output with its own value.

Neither override is ever written into the direction register, so software can do read-modify-write on that register safely. Pad inputs arrive already synchronized.

The register interface uses plain strobes, not a stream:

- A write is taken on every clock edge where `reg_wr` is high.
- A read is taken on every clock edge where `reg_rd` is high, and the data appears on `reg_rdata` one cycle later.
- There is no ready signal. The port never applies back-pressure, so a strobe can be presented on every cycle.

Address map:

| `reg_addr` | Register |
|---|---|
| 0 | Port |
| 1 | Latch |
| 2 | Direction |
| 3 | Reserved |

Top module: `gpio6_port`

## Requirements
- R1: After reset the direction register reads 0x1F, the latch reads 0x00, `pad_oe` is 0 on all five pins, and `reg_rdata` is 0.
- R2: With no override active, a direction bit of 0 sets `pad_oe` for that pin and drives the latch bit on `pad_out`. A direction bit of 1 clears `pad_oe`. `pad_out` is 0 on every pin whose `pad_oe` is 0. Pad signals change on the same edge that takes the register write.
- R3: A read of address 1 (latch) returns the latch contents, whatever the pad levels are.
- R4: A read of address 0 (port) returns the synchronized `pad_in` levels. A write to address 0 updates the latch exactly as a write to address 1 does.
- R5: When `periph_ovr_en[i]` is 1, `periph_ovr_dir[i]` selects the pad direction (1 = input, 0 = output driving `periph_ovr_out[i]`). A read of address 2 still returns the value software wrote.
- R6: When `lcd_seg_en[i]` is 1, pin i drives `lcd_seg_val[i]` with `pad_oe` set, overriding any peripheral override. The pin's bit in a port read is 0.
- R7: Bit 5 of the direction and latch registers ignores writes and reads as 0. Bits 7:6 of every read are 0.
- R8: With `cfg_mrst_en` = 0, bit 5 of a port read equals `pad_in[5]`, and `mrst_req` stays 0.
- R9: With `cfg_mrst_en` = 1, bit 5 of a port read is 0, and `mrst_req` is 1 exactly while `pad_in[5]` is 0.
- R10: `reg_rdata` is updated one cycle after the edge that samples `reg_rd`, and holds its value on cycles without a read. Address 3 reads as 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cfg_mrst_en | input | 1 | Selects the role of pin 5: 1 = master-reset input, 0 = digital input |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| pad_in | input | 6 | Synchronized pad input levels |
| periph_ovr_en | input | 5 | Peripheral override enable, one bit per pin |
| periph_ovr_dir | input | 5 | Direction forced by the peripheral (1 = input) |
| periph_ovr_out | input | 5 | Output value forced by the peripheral |
| lcd_seg_en | input | 5 | LCD segment claims the pin |
| lcd_seg_val | input | 5 | Segment drive value |
| pad_oe | output | 5 | Pad output enable |
| pad_out | output | 5 | Pad output value |
| mrst_req | output | 1 | Reset request from pin 5 |

## Verification
The pad outputs and `mrst_req` follow the overrides and `pad_in` in the same cycle, and follow a register write from the edge that takes it. The bench therefore drives on the falling edge and checks these signals at the next falling edge. Read data is due one edge after `reg_rd` is sampled. Each read task raises the strobe for one cycle and compares `reg_rdata` at the falling edge that follows. The hold check then waits through further idle cycles, and through a write, before it compares again.

// File: rtl/gpio6_pkg.sv
package gpio6_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_PORT = 2'd0,
    A_LAT  = 2'd1,
    A_DIR  = 2'd2,
    A_RSVD = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/gpio6_regfile.sv
module gpio6_regfile
  import gpio6_pkg::*;
#(
  parameter int NB = 5,
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [NB-1:0]     dir_q,
  output logic [NB-1:0]     lat_q
);
  logic lat_hit, dir_hit;

  always_comb begin
    lat_hit = wr && ((addr == A_LAT) || (addr == A_PORT));
    dir_hit = wr && (addr == A_DIR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
      lat_q <= '0;
    end else begin
      if (lat_hit) lat_q <= wdata[NB-1:0];
      if (dir_hit) dir_q <= wdata[NB-1:0];
    end
  end
endmodule

// File: rtl/gpio6_pin_mux.sv
module gpio6_pin_mux (
  input  logic dir_bit,
  input  logic lat_bit,
  input  logic pov_en,
  input  logic pov_dir,
  input  logic pov_out,
  input  logic seg_en,
  input  logic seg_val,
  input  logic pin_in,
  output logic oe,
  output logic out,
  output logic rd_bit
);
  always_comb begin
    if (seg_en) begin
      oe     = 1'b1;
      out    = seg_val;
      rd_bit = 1'b0;
    end else if (pov_en) begin
      oe     = !pov_dir;
      out    = pov_dir ? 1'b0 : pov_out;
      rd_bit = pin_in;
    end else begin
      oe     = !dir_bit;
      out    = dir_bit ? 1'b0 : lat_bit;
      rd_bit = pin_in;
    end
  end
endmodule

// File: rtl/gpio6_rdmux.sv
module gpio6_rdmux
  import gpio6_pkg::*;
#(
  parameter int NB = 5,
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NB:0]       port_bits,
  input  logic [NB-1:0]     lat_q,
  input  logic [NB-1:0]     dir_q,
  output logic [DW-1:0]     rdata
);
  logic [DW-1:0] sel;

  always_comb begin
    sel = '0;
    unique case (addr)
      A_PORT:  sel[NB:0]   = port_bits;
      A_LAT:   sel[NB-1:0] = lat_q;
      A_DIR:   sel[NB-1:0] = dir_q;
      default: sel         = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= sel;
  end
endmodule

// File: rtl/gpio6_port.sv
module gpio6_port
  import gpio6_pkg::*;
#(
  parameter int NB = 5,
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mrst_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic              reg_rd,
  output logic [DW-1:0]     reg_rdata,
  input  logic [NB:0]       pad_in,
  input  logic [NB-1:0]     periph_ovr_en,
  input  logic [NB-1:0]     periph_ovr_dir,
  input  logic [NB-1:0]     periph_ovr_out,
  input  logic [NB-1:0]     lcd_seg_en,
  input  logic [NB-1:0]     lcd_seg_val,
  output logic [NB-1:0]     pad_oe,
  output logic [NB-1:0]     pad_out,
  output logic              mrst_req
);
  localparam int NP = NB + 1;

  logic [NB-1:0] dir_q, lat_q;
  logic [NP-1:0] port_bits;

  gpio6_regfile #(.NB(NB), .DW(DW)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .dir_q (dir_q),
    .lat_q (lat_q)
  );

  for (genvar i = 0; i < NB; i++) begin : g_pin
    gpio6_pin_mux u_mux (
      .dir_bit (dir_q[i]),
      .lat_bit (lat_q[i]),
      .pov_en  (periph_ovr_en[i]),
      .pov_dir (periph_ovr_dir[i]),
      .pov_out (periph_ovr_out[i]),
      .seg_en  (lcd_seg_en[i]),
      .seg_val (lcd_seg_val[i]),
      .pin_in  (pad_in[i]),
      .oe      (pad_oe[i]),
      .out     (pad_out[i]),
      .rd_bit  (port_bits[i])
    );
  end

  always_comb begin
    port_bits[NB] = cfg_mrst_en ? 1'b0 : pad_in[NB];
    mrst_req      = cfg_mrst_en && !pad_in[NB];
  end

  gpio6_rdmux #(.NB(NB), .DW(DW)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd        (reg_rd),
    .addr      (reg_addr),
    .port_bits (port_bits),
    .lat_q     (lat_q),
    .dir_q     (dir_q),
    .rdata     (reg_rdata)
  );
endmodule

// File: rtl/gpio6_port_chk.sv
module gpio6_port_chk
  import gpio6_pkg::*;
#(
  parameter int NB = 5,
  parameter int DW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_mrst_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_rd,
  input logic [DW-1:0]     reg_rdata,
  input logic [NB-1:0]     periph_ovr_en,
  input logic [NB-1:0]     periph_ovr_dir,
  input logic [NB-1:0]     lcd_seg_en,
  input logic [NB-1:0]     lcd_seg_val,
  input logic [NB-1:0]     pad_oe,
  input logic [NB-1:0]     pad_out,
  input logic              mrst_req
);
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  a_r2_quiet_when_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);

  a_r6_lcd_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((lcd_seg_en & ~pad_oe) == '0) && ((lcd_seg_en & (pad_out ^ lcd_seg_val)) == '0));

  a_r5_forced_input: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_ovr_en & ~lcd_seg_en & periph_ovr_dir & pad_oe) == '0);

  a_r7_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DW-1:NB+1] == '0);

  a_r7_bit5_dir_lat: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && reg_rd && (reg_addr == A_DIR || reg_addr == A_LAT)) |=> !reg_rdata[NB]);

  a_r8_no_req_as_input: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mrst_en |-> !mrst_req);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !reg_rd) |=> $stable(reg_rdata));
endmodule

bind gpio6_port gpio6_port_chk #(.NB(NB), .DW(DW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_mrst_en    (cfg_mrst_en),
  .reg_addr       (reg_addr),
  .reg_rd         (reg_rd),
  .reg_rdata      (reg_rdata),
  .periph_ovr_en  (periph_ovr_en),
  .periph_ovr_dir (periph_ovr_dir),
  .lcd_seg_en     (lcd_seg_en),
  .lcd_seg_val    (lcd_seg_val),
  .pad_oe         (pad_oe),
  .pad_out        (pad_out),
  .mrst_req       (mrst_req)
);

// File: tb/sim_gpio6_port.sv
`timescale 1ns/1ps
module sim_gpio6_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_mrst_en = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic [5:0] pad_in = '0;
  logic [4:0] periph_ovr_en = '0, periph_ovr_dir = '0, periph_ovr_out = '0;
  logic [4:0] lcd_seg_en = '0, lcd_seg_val = '0;
  logic [4:0] pad_oe, pad_out;
  logic       mrst_req;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  gpio6_port u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mrst_en(cfg_mrst_en),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .periph_ovr_en(periph_ovr_en), .periph_ovr_dir(periph_ovr_dir),
    .periph_ovr_out(periph_ovr_out), .lcd_seg_en(lcd_seg_en),
    .lcd_seg_val(lcd_seg_val), .pad_oe(pad_oe), .pad_out(pad_out),
    .mrst_req(mrst_req)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 oe", {3'b0, pad_oe}, 8'h00);
    check("R1 rdata", reg_rdata, 8'h00);
    rd_reg(2'd2, v); check("R1 dir", v, 8'h1F);
    rd_reg(2'd1, v); check("R1 lat", v, 8'h00);
    check("R8 mrst idle", {7'b0, mrst_req}, 8'h00);
  endtask

  task automatic t_drive;
    wr_reg(2'd1, 8'h15);
    wr_reg(2'd2, 8'h04);
    check("R2 oe", {3'b0, pad_oe}, 8'h1B);
    check("R2 out", {3'b0, pad_out}, 8'h11);
  endtask

  task automatic t_latch;
    logic [7:0] v;
    pad_in = 6'h00;
    @(negedge clk);
    rd_reg(2'd1, v); check("R3 latch not pins", v, 8'h15);
    wr_reg(2'd0, 8'h0A);
    rd_reg(2'd1, v); check("R4 port write hits latch", v, 8'h0A);
    check("R4 out", {3'b0, pad_out}, 8'h0A);
  endtask

  task automatic t_port_read;
    logic [7:0] v;
    cfg_mrst_en = 1'b0;
    pad_in = 6'h2A;
    @(negedge clk);
    rd_reg(2'd0, v); check("R4 port read", v, 8'h2A);
    pad_in = 6'h20;
    @(negedge clk);
    rd_reg(2'd0, v); check("R8 pin5 input", v, 8'h20);
    check("R8 no req", {7'b0, mrst_req}, 8'h00);
  endtask

  task automatic t_periph;
    logic [7:0] v;
    periph_ovr_en = 5'h03; periph_ovr_dir = 5'h01; periph_ovr_out = 5'h02;
    @(negedge clk);
    check("R5 oe", {3'b0, pad_oe}, 8'h1A);
    check("R5 out", {3'b0, pad_out}, 8'h0A);
    rd_reg(2'd2, v); check("R5 dir untouched", v, 8'h04);
  endtask

  task automatic t_lcd;
    logic [7:0] v;
    lcd_seg_en = 5'h03; lcd_seg_val = 5'h01; pad_in = 6'h1F;
    @(negedge clk);
    check("R6 oe", {3'b0, pad_oe}, 8'h1B);
    check("R6 out", {3'b0, pad_out}, 8'h09);
    rd_reg(2'd0, v); check("R6 port masked", v, 8'h1C);
    lcd_seg_en = '0; periph_ovr_en = '0;
    @(negedge clk);
    check("R2 back to regs", {3'b0, pad_oe}, 8'h1B);
  endtask

  task automatic t_bit5;
    logic [7:0] v;
    wr_reg(2'd2, 8'hFF);
    rd_reg(2'd2, v); check("R7 dir bit5", v, 8'h1F);
    wr_reg(2'd1, 8'hE0);
    rd_reg(2'd1, v); check("R7 lat bit5", v, 8'h00);
  endtask

  task automatic t_mrst;
    logic [7:0] v;
    cfg_mrst_en = 1'b1; pad_in = 6'h20;
    @(negedge clk);
    check("R9 high no req", {7'b0, mrst_req}, 8'h00);
    rd_reg(2'd0, v); check("R9 bit5 masked", v, 8'h00);
    pad_in = 6'h00;
    @(negedge clk);
    check("R9 low req", {7'b0, mrst_req}, 8'h01);
    cfg_mrst_en = 1'b0; pad_in = 6'h20;
    @(negedge clk);
  endtask

  task automatic t_rdpath;
    logic [7:0] v;
    rd_reg(2'd2, v); check("R10 read", v, 8'h1F);
    wr_reg(2'd2, 8'h00);
    repeat (3) @(negedge clk);
    check("R10 hold", reg_rdata, 8'h1F);
    rd_reg(2'd3, v); check("R10 rsvd reads 0", v, 8'h00);
    wr_reg(2'd3, 8'hFF);
    rd_reg(2'd2, v); check("R10 rsvd write dir", v, 8'h00);
    rd_reg(2'd1, v); check("R10 rsvd write lat", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_drive();
    t_latch();
    t_port_read();
    t_periph();
    t_lcd();
    t_bit5();
    t_mrst();
    t_rdpath();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule